// File: doc/BRIEF.md
# Packet-Command Device Handshake Engine

This block sits on the device side of a parallel disk-style register interface and runs the handshake a packet-command drive performs when a command returns data to the host. The host programs a transfer-size ceiling and a feature byte, then writes the packet opcode into the command register. The engine raises busy and walks through the phase-change sequence. It accepts twelve command bytes through the data register and hands them, with the latched feature byte, to a local back end.

The back end answers with a response length. The engine publishes the smaller of that length and the host ceiling in the byte-count register. It then streams exactly that many bytes from the back end through data-register reads, and closes with a status phase that raises the interrupt line. Any other opcode is rejected: the engine reports an abort and goes directly to the status phase.

The status, reason and interrupt indications change one bit per clock cycle in a fixed order. Busy and data-request are therefore never seen set together. A host read of the status register drops the interrupt line.

Top module: `atapi_pkt_dev`

## Requirements
- R1: After reset the status register (address 7) reads 8'h40, where bit 7 is busy, bit 6 is device-ready, bit 3 is data-request and bit 0 is error. The reason register (address 2, bit 0 command/data, bit 1 direction-to-host) reads 0, and the interrupt output is low.
- R2: Writing 8'hA0 to address 7 while idle sets busy on the next cycle. Then, on successive cycles, command/data is set, direction is cleared, busy is cleared and data-request is set, in that order. Busy and data-request are never both set.
- R3: The twelve bytes written to address 0 during the packet phase appear in `pkt_bytes`, with byte k at bits 8k+7:8k. After the twelfth write, data-request clears. On the following cycle busy sets and `pkt_valid` pulses for one cycle, with `pkt_feat` holding the byte last written to address 1.
- R4: The byte count (addresses 4 low and 5 high) is loaded with the smaller of `be_len` and the ceiling the host wrote there while idle. Host writes to these addresses outside the idle state are ignored.
- R5: On entering the data phase the engine sets direction, clears command/data, clears busy and sets data-request on successive cycles, and then raises the interrupt.
- R6: A host read of address 7 clears the interrupt output on the next cycle.
- R7: Data reads in the data phase return the back-end bytes in order, pulsing `be_pop` once each. Data-request clears after the last counted byte.
- R8: In the status phase, command/data, direction and device-ready are set and busy and data-request are clear, and the interrupt is raised one cycle later. A count of zero skips the data phase.
- R9: Any opcode other than 8'hA0 sets the error status bit and bit 2 (abort) of the error register at address 1. The engine goes straight to the status phase without a packet phase or a `pkt_valid` pulse.
- R10: A read of address 0 outside the data phase returns 0, does not pulse `be_pop` and leaves the status unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data (combinational) |
| bsy | output | 1 | Busy indication |
| drq | output | 1 | Data-request indication |
| drdy | output | 1 | Device-ready indication |
| cod | output | 1 | Command/data phase indication |
| io | output | 1 | Direction-to-host indication |
| intrq | output | 1 | Interrupt request |
| pkt_valid | output | 1 | One-cycle pulse: packet captured |
| pkt_bytes | output | 96 | Captured packet, byte 0 lowest |
| pkt_feat | output | 8 | Feature byte latched with the packet |
| be_done | input | 1 | Back end has a response ready |
| be_len | input | BC_W | Response length in bytes |
| be_pop | output | 1 | Consume one response byte |
| be_data | input | 8 | Current response byte |

## Verification
The bench builds the engine with its default 16-bit byte count. This lets ceilings and response lengths above 255 exercise the high byte-count register. It also covers the zero-ceiling and zero-length cases that skip the data phase, and lengths that land on either side of the ceiling or equal it exactly.

// File: rtl/atapi_pkt_dev.sv
`timescale 1ns/1ps
module atapi_pkt_dev #(
  parameter int BC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      host_addr,
  input  logic            host_wr,
  input  logic            host_rd,
  input  logic [7:0]      host_wdata,
  output logic [7:0]      host_rdata,
  output logic            bsy,
  output logic            drq,
  output logic            drdy,
  output logic            cod,
  output logic            io,
  output logic            intrq,
  output logic            pkt_valid,
  output logic [95:0]     pkt_bytes,
  output logic [7:0]      pkt_feat,
  input  logic            be_done,
  input  logic [BC_W-1:0] be_len,
  output logic            be_pop,
  input  logic [7:0]      be_data
);

  localparam int          PKT_N   = 12;
  localparam int          IDX_W   = $clog2(PKT_N);
  localparam logic [7:0]  OP_PKT  = 8'hA0;
  localparam logic [7:0]  ABRT    = 8'h04;

  typedef enum logic [4:0] {
    S_IDLE, S_A1, S_A2, S_A3, S_A4, S_PKT, S_P1, S_WAIT,
    S_D1, S_D2, S_D3, S_D4, S_D5, S_D6, S_DATA, S_C1, S_C2
  } st_t;

  st_t              state;
  logic             bsy_q, drq_q, drdy_q, cod_q, io_q, intrq_q, err_q, pv_q;
  logic [7:0]       errreg_q, feat_q, featl_q;
  logic [BC_W-1:0]  bc_q, lim_q, resp_q, rem_q;
  logic [IDX_W-1:0] idx_q;
  logic [95:0]      pkt_q;

  wire wr_data = host_wr && host_addr == 3'd0;
  wire rd_data = host_rd && host_addr == 3'd0;
  wire wr_cmd  = host_wr && host_addr == 3'd7;
  wire rd_stat = host_rd && host_addr == 3'd7;
  wire [BC_W-1:0] xfer = (resp_q < lim_q) ? resp_q : lim_q;
  wire [7:0] status = {bsy_q, drdy_q, 2'b00, drq_q, 2'b00, err_q};

  assign bsy = bsy_q;
  assign drq = drq_q;
  assign drdy = drdy_q;
  assign cod = cod_q;
  assign io = io_q;
  assign intrq = intrq_q;
  assign pkt_valid = pv_q;
  assign pkt_bytes = pkt_q;
  assign pkt_feat = featl_q;
  assign be_pop = rd_data && state == S_DATA;

  always_comb begin
    case (host_addr)
      3'd0:    host_rdata = (state == S_DATA) ? be_data : 8'h00;
      3'd1:    host_rdata = errreg_q;
      3'd2:    host_rdata = {6'b0, io_q, cod_q};
      3'd4:    host_rdata = bc_q[7:0];
      3'd5:    host_rdata = 8'(bc_q >> 8);
      3'd7:    host_rdata = status;
      default: host_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      bsy_q <= 1'b0; drq_q <= 1'b0; drdy_q <= 1'b1; cod_q <= 1'b0; io_q <= 1'b0;
      intrq_q <= 1'b0; err_q <= 1'b0; pv_q <= 1'b0;
      errreg_q <= '0; feat_q <= '0; featl_q <= '0;
      bc_q <= '0; lim_q <= '0; resp_q <= '0; rem_q <= '0;
      idx_q <= '0; pkt_q <= '0;
    end else begin
      pv_q <= 1'b0;
      if (host_wr && host_addr == 3'd1) feat_q <= host_wdata;
      if (state == S_IDLE && host_wr && host_addr == 3'd4) bc_q[7:0] <= host_wdata;
      if (state == S_IDLE && host_wr && host_addr == 3'd5) bc_q[BC_W-1:8] <= host_wdata[BC_W-9:0];
      if (rd_stat) intrq_q <= 1'b0;
      case (state)
        S_IDLE: if (wr_cmd) begin
          intrq_q <= 1'b0;
          if (host_wdata == OP_PKT) begin
            bsy_q <= 1'b1; err_q <= 1'b0; errreg_q <= '0; idx_q <= '0;
            state <= S_A1;
          end else begin
            err_q <= 1'b1; errreg_q <= ABRT;
            state <= S_C1;
          end
        end
        S_A1: begin cod_q <= 1'b1; state <= S_A2; end
        S_A2: begin io_q  <= 1'b0; state <= S_A3; end
        S_A3: begin bsy_q <= 1'b0; state <= S_A4; end
        S_A4: begin drq_q <= 1'b1; state <= S_PKT; end
        S_PKT: if (wr_data) begin
          pkt_q[idx_q*8 +: 8] <= host_wdata;
          idx_q <= idx_q + 1'b1;
          if (idx_q == IDX_W'(PKT_N - 1)) begin
            drq_q <= 1'b0;
            state <= S_P1;
          end
        end
        S_P1: begin
          bsy_q <= 1'b1; lim_q <= bc_q; featl_q <= feat_q; pv_q <= 1'b1;
          state <= S_WAIT;
        end
        S_WAIT: if (be_done) begin resp_q <= be_len; state <= S_D1; end
        S_D1: begin
          bc_q <= xfer; rem_q <= xfer;
          state <= (xfer == '0) ? S_C1 : S_D2;
        end
        S_D2: begin io_q  <= 1'b1; state <= S_D3; end
        S_D3: begin cod_q <= 1'b0; state <= S_D4; end
        S_D4: begin bsy_q <= 1'b0; state <= S_D5; end
        S_D5: begin drq_q <= 1'b1; state <= S_D6; end
        S_D6: begin intrq_q <= 1'b1; state <= S_DATA; end
        S_DATA: if (rd_data) begin
          rem_q <= rem_q - 1'b1;
          if (rem_q == BC_W'(1)) begin
            drq_q <= 1'b0;
            state <= S_C1;
          end
        end
        S_C1: begin
          cod_q <= 1'b1; io_q <= 1'b1; drdy_q <= 1'b1; bsy_q <= 1'b0; drq_q <= 1'b0;
          state <= S_C2;
        end
        S_C2: begin intrq_q <= 1'b1; state <= S_IDLE; end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  no_bsy_drq_chk: assert property (@(posedge clk) disable iff (!rst_n) !(bsy_q && drq_q));
  // R6
  intrq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && state != S_D6 && state != S_C2) |=> !intrq_q);
  // R10
  pop_needs_drq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    be_pop |-> (drq_q && io_q && !cod_q));
  // R4
  bc_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_DATA) |-> (bc_q <= lim_q && bc_q <= resp_q));
  // R8
  done_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(intrq_q) && cod_q) |-> (io_q && drdy_q && !bsy_q && !drq_q));
  // R5
  data_intrq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(intrq_q) && !cod_q) |-> (io_q && drq_q && !bsy_q));
  // R3
  pkt_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pv_q |-> (bsy_q && !drq_q));

endmodule

// File: tb/atapi_pkt_dev_tb.sv
`timescale 1ns/1ps
module atapi_pkt_dev_tb;
  localparam int BC_W = 16;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr = 0, rd = 0, be_done = 0;
  logic [7:0] wdata = 0, rdata, be_data;
  logic [BC_W-1:0] be_len = 0;
  logic bsy, drq, drdy, cod, io, intrq, pkt_valid, be_pop;
  logic [95:0] pkt_bytes;
  logic [7:0] pkt_feat;
  logic [7:0] bcnt = 0, exp_seq = 0;
  int pv_cnt = 0, total = 0, fails = 0;

  always #5 clk = ~clk;

  atapi_pkt_dev #(.BC_W(BC_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(addr), .host_wr(wr), .host_rd(rd),
    .host_wdata(wdata), .host_rdata(rdata), .bsy(bsy), .drq(drq), .drdy(drdy),
    .cod(cod), .io(io), .intrq(intrq), .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes),
    .pkt_feat(pkt_feat), .be_done(be_done), .be_len(be_len), .be_pop(be_pop),
    .be_data(be_data));

  assign be_data = bcnt ^ 8'h5A;
  always @(posedge clk) begin
    if (be_pop) bcnt <= bcnt + 8'd1;
    if (pkt_valid) pv_cnt <= pv_cnt + 1;
  end

  localparam logic [31:0] VEC [7] = '{
    {16'd20, 16'd100}, {16'd200, 16'd16}, {16'd0, 16'd50}, {16'd7, 16'd7},
    {16'd300, 16'd1}, {16'd5, 16'd0}, {16'd260, 16'd300}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1; #1 d = rdata;
    @(negedge clk); rd = 0;
  endtask

  task automatic wait_intrq(output bit ok);
    ok = 0;
    for (int k = 0; k < 80; k++) begin
      if (intrq) begin ok = 1; break; end
      @(negedge clk);
    end
  endtask

  task automatic run(input logic [15:0] len, input logic [15:0] lim, input logic [7:0] seed);
    logic [7:0] d, lo, hi;
    int t_cod, t_bclr, t_drq;
    logic io_at_drq, saw_bsy;
    bit ok;
    logic [15:0] n;
    n = (len < lim) ? len : lim;
    hwr(3'd4, lim[7:0]); hwr(3'd5, lim[15:8]); hwr(3'd1, seed ^ 8'hFF);
    @(negedge clk); addr = 3'd7; wdata = 8'hA0; wr = 1;
    @(negedge clk); wr = 0;
    saw_bsy = bsy; t_cod = -1; t_bclr = -1; t_drq = -1; io_at_drq = 1'b1;
    for (int k = 0; k < 16; k++) begin
      if (cod && t_cod < 0) t_cod = k;
      if (!bsy && t_bclr < 0) t_bclr = k;
      if (drq && t_drq < 0) begin t_drq = k; io_at_drq = io; end
      chk("R2 busy with drq", 32'(bsy && drq), 0);
      @(negedge clk);
    end
    chk("R2 busy first", 32'(saw_bsy), 1);
    chk("R2 cod before busy clear", 32'(t_cod >= 0 && t_cod < t_bclr), 1);
    chk("R2 busy clear before drq", 32'(t_bclr < t_drq), 1);
    chk("R2 io clear at drq", 32'(io_at_drq), 0);
    for (int i = 0; i < 12; i++) hwr(3'd0, seed + 8'(i));
    chk("R3 drq clear after 12th", 32'(drq), 0);
    @(negedge clk);
    chk("R3 pkt_valid", 32'(pkt_valid), 1);
    chk("R3 busy set", 32'(bsy), 1);
    for (int i = 0; i < 12; i++) chk("R3 packet byte", 32'(pkt_bytes[i*8 +: 8]), 32'(seed + 8'(i)));
    chk("R3 feature", 32'(pkt_feat), 32'(seed ^ 8'hFF));
    @(negedge clk); be_done = 1; be_len = len;
    @(negedge clk); be_done = 0;
    wait_intrq(ok);
    chk("R8/R5 interrupt raised", 32'(ok), 1);
    if (n != 0) begin
      chk("R5 io", 32'(io), 1); chk("R5 cod", 32'(cod), 0);
      chk("R5 drq", 32'(drq), 1); chk("R5 bsy", 32'(bsy), 0);
      hrd(3'd4, lo); hrd(3'd5, hi);
      chk("R4 byte count", 32'({hi, lo}), 32'(n));
      hrd(3'd7, d);
      chk("R6 status in data", 32'(d), 32'h48);
      chk("R6 intrq cleared", 32'(intrq), 0);
      for (int i = 0; i < int'(n); i++) begin
        hrd(3'd0, d);
        chk("R7 data byte", 32'(d), 32'(exp_seq ^ 8'h5A));
        exp_seq = exp_seq + 8'd1;
      end
      chk("R7 drq clear after last", 32'(drq), 0);
      wait_intrq(ok);
      chk("R8 interrupt raised", 32'(ok), 1);
    end else begin
      hrd(3'd4, lo); hrd(3'd5, hi);
      chk("R4 zero count", 32'({hi, lo}), 0);
    end
    chk("R8 cod", 32'(cod), 1); chk("R8 io", 32'(io), 1);
    chk("R8 bsy/drq", 32'({bsy, drq}), 0);
    hrd(3'd7, d);
    chk("R8 final status", 32'(d), 32'h40);
    chk("R6 intrq cleared", 32'(intrq), 0);
    chk("R7 pop count", 32'(bcnt), 32'(exp_seq));
  endtask

  initial begin
    #1ms;
    fails++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] d;
    bit ok;
    int pv0;
    logic [7:0] b0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    hrd(3'd7, d); chk("R1 status", 32'(d), 32'h40);
    hrd(3'd2, d); chk("R1 reason", 32'(d), 0);
    chk("R1 intrq", 32'(intrq), 0);

    b0 = bcnt;
    hrd(3'd0, d);
    chk("R10 idle data read", 32'(d), 0);
    chk("R10 no pop", 32'(bcnt), 32'(b0));
    hrd(3'd7, d); chk("R10 status unchanged", 32'(d), 32'h40);

    for (int v = 0; v < 7; v++)
      run(VEC[v][31:16], VEC[v][15:0], 8'(v * 16 + 3));

    pv0 = pv_cnt;
    hwr(3'd7, 8'hEC);
    wait_intrq(ok);
    chk("R9 interrupt", 32'(ok), 1);
    hrd(3'd1, d); chk("R9 abort bit", 32'(d), 32'h04);
    hrd(3'd2, d); chk("R9 reason", 32'(d), 3);
    hrd(3'd7, d); chk("R9 error status", 32'(d), 32'h41);
    chk("R9 no packet", 32'(pv_cnt), 32'(pv0));

    b0 = bcnt;
    hrd(3'd0, d);
    chk("R10 read after abort", 32'(d), 0);
    chk("R10 no pop after abort", 32'(bcnt), 32'(b0));

    run(16'd3, 16'd10, 8'hC0);
    hrd(3'd1, d); chk("R9 error cleared by new command", 32'(d), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule